// File: doc/BRIEF.md
# Interleaved I/Q Converter Feed Sequencer

This block sits between a host sample stream and a dual-channel digital-to-analog converter that is run in its interleaved mode. The host offers I/Q sample pairs over a valid/ready handshake. The block places each pair on one shared data bus. It writes I into the first channel's input latch and Q into the second channel's input latch, choosing the target with a channel-select line. A divided update clock then moves both latches into the converter together.

The update clock runs at half the system clock, so every level lasts one system cycle. A pair occupies four system cycles. I is written with the select line at 1 on the first rising update edge, and Q is written with the select line at 0 on the second. Data and select change only on falling update edges.

The converter divides the update clock by two, and that divider is cleared by a reset line. After a system reset, the block holds that line high for a fixed time. It then runs one priming pair with the line still high, and releases the line while the update clock is low. As a result, the first rising update edge after the release, and every second edge after that, commits a pair whose two writes are both complete. If no pair is offered when one is needed, the previous pair is sent again and an underrun pulse is raised.

Top module: `iqdac_feed`

## Requirements
- R1: Reset values are as follows. `div_rst` is 1. `bus_data`, `bus_wr`, `bus_chsel`, `upd_clk`, `in_ready` and `underrun` are all 0.
- R2: An I sample is written, meaning `bus_wr` rises, with `bus_chsel` = 1. A Q sample is written with `bus_chsel` = 0. The bus carries the sample unchanged as 8-bit straight binary.
- R3: `bus_chsel` changes only in a cycle in which both `upd_clk` and `bus_wr` are 0.
- R4: `bus_wr` rises only in the same cycle in which `upd_clk` rises.
- R5: Once priming has begun, `upd_clk` toggles every system cycle, giving half rate and a 50% duty cycle. `bus_data` changes only in cycles where `upd_clk` is 0, so it changes on falling update edges.
- R6: After reset, `div_rst` stays high for HOLD_CYC+4 cycles: the hold time plus one priming pair. It falls in a cycle where `upd_clk` is 0. The first rising `upd_clk` after the fall, and every second one after that, finds both channel latches written since the previous commit.
- R7: `in_ready` is high for the first time in cycle HOLD_CYC-1 after reset, counting the first cycle out of reset as 0. After that it is high for exactly one cycle in every four.
- R8: If `in_ready` is high while `in_valid` is 0, the previously accepted pair is sent again, or zeros if no pair has been accepted since reset. In that case `underrun` is high for exactly the next cycle.
- R9: A synchronous reset in the middle of a stream returns every output to its R1 value and restarts the whole start-up sequence.
- R10: Pairs are committed in the order they were accepted, one every four cycles, and the first commit falls in cycle HOLD_CYC+5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host offers a pair |
| in_i | input | DATA_W | I sample |
| in_q | input | DATA_W | Q sample |
| in_ready | output | 1 | Pair is taken at this edge if valid |
| bus_data | output | DATA_W | Shared converter data bus |
| bus_wr | output | 1 | Channel latch write strobe |
| bus_chsel | output | 1 | Channel select: 1 for I, 0 for Q |
| upd_clk | output | 1 | Update clock, half system rate |
| div_rst | output | 1 | Clears the converter's internal divide-by-two |
| underrun | output | 1 | One-cycle pulse when a pair was repeated |

## Verification
Two events share a cycle on every pair boundary. The rising update edge that commits the previous pair is also the rising write edge that loads the next I sample, so a wrong order would commit the new I in place of the old one. Continuous streaming with distinct pairs, including all-ones and all-zeros, exercises this boundary every four cycles. The bench's converter model applies each commit before the write that shares its cycle, then compares the committed values with the queue of accepted pairs. A second coincidence occurs when the host withholds a pair: the underrun case shares its cycle with the I load. Gapped valid patterns and a start with no data at all provoke it.

// File: rtl/iqdac_pkg.sv
package iqdac_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    // Position within a four-cycle pair period.
    typedef enum logic [1:0] {
        PH_WR_I = 2'd0,   // update clock high, I strobed
        PH_LD_Q = 2'd1,   // update clock low, Q placed on bus
        PH_WR_Q = 2'd2,   // update clock high, Q strobed
        PH_LD_I = 2'd3    // update clock low, next I placed on bus
    } phase_e;

    typedef struct packed {
        seq_state_e st;
        phase_e     ph;
    } slot_t;

    function automatic phase_e next_phase(input phase_e ph);
        return phase_e'(ph + 2'd1);
    endfunction

    function automatic logic is_high_phase(input phase_e ph);
        return (ph == PH_WR_I) || (ph == PH_WR_Q);
    endfunction

    function automatic logic is_active(input slot_t s);
        return s.st != ST_HOLD;
    endfunction

endpackage

// File: rtl/iqdac_seq.sv
module iqdac_seq
    import iqdac_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic  clk,
    input  logic  rst,
    output slot_t slot_nxt,
    output logic  take_o
);
    localparam int unsigned CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    slot_t            slot_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic             take_n;

    initial begin
        if (HOLD_CYC < 2) $error("HOLD_CYC must be at least 2");
    end

    always_comb begin
        slot_nxt = slot_q;
        cnt_n    = cnt_q;
        unique case (slot_q.st)
            ST_HOLD: begin
                if (cnt_q == CNT_LAST) begin
                    slot_nxt.st = ST_PRIME;
                    slot_nxt.ph = PH_LD_I;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_PRIME: begin
                slot_nxt.ph = next_phase(slot_q.ph);
                if (slot_q.ph == PH_WR_Q) slot_nxt.st = ST_RUN;
            end
            default: slot_nxt.ph = next_phase(slot_q.ph);
        endcase
        take_n = is_active(slot_nxt) ? (slot_nxt.ph == PH_WR_Q)
                                     : (cnt_n == CNT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{st: ST_HOLD, ph: PH_WR_I};
            cnt_q  <= '0;
            take_o <= 1'b0;
        end else begin
            slot_q <= slot_nxt;
            cnt_q  <= cnt_n;
            take_o <= take_n;
        end
    end

    // R7: a take slot is never followed directly by another
    assert_take_single_R7: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    // R6: once the divider is released the sequencer never re-enters hold
    assert_run_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (slot_q.st == ST_RUN) |=> (slot_q.st == ST_RUN));

endmodule

// File: rtl/iqdac_pair_hold.sv
module iqdac_pair_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] load_i,
    output logic [DATA_W-1:0] held_q,
    output logic              underrun_o
);
    logic [DATA_W-1:0] held_i;
    logic              accept;

    assign accept = take && in_valid;
    assign load_i = accept ? in_i : held_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_i     <= '0;
            held_q     <= '0;
            underrun_o <= 1'b0;
        end else begin
            underrun_o <= take && !in_valid;
            if (accept) begin
                held_i <= in_i;
                held_q <= in_q;
            end
        end
    end

    // R8: underrun is a single-cycle pulse
    assert_underrun_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        underrun_o |=> !underrun_o);

    // R8: a missed slot leaves the repeated pair untouched
    assert_repeat_pair_R8: assert property (@(posedge clk) disable iff (rst)
        underrun_o |-> ($stable(held_i) && $stable(held_q)));

endmodule

// File: rtl/iqdac_pins.sv
module iqdac_pins
    import iqdac_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             slot_nxt,
    input  logic [DATA_W-1:0] load_i,
    input  logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] data_q,
    output logic              wr_q,
    output logic              chsel_q,
    output logic              uclk_q,
    output logic              drst_q
);
    logic active_n;
    logic high_n;

    assign active_n = is_active(slot_nxt);
    assign high_n   = active_n && is_high_phase(slot_nxt.ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            wr_q    <= 1'b0;
            chsel_q <= 1'b0;
            uclk_q  <= 1'b0;
            drst_q  <= 1'b1;
        end else begin
            uclk_q <= high_n;
            wr_q   <= high_n;
            drst_q <= (slot_nxt.st != ST_RUN);
            if (active_n && slot_nxt.ph == PH_LD_I) begin
                data_q  <= load_i;
                chsel_q <= 1'b1;
            end else if (active_n && slot_nxt.ph == PH_LD_Q) begin
                data_q  <= load_q;
                chsel_q <= 1'b0;
            end
        end
    end

    // R3: select moves only while strobe and update clock are both low
    assert_sel_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(chsel_q) |-> (!uclk_q && !wr_q));

    // R4: a write strobe never rises ahead of the update clock
    assert_wr_with_clk_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_q) |-> (uclk_q && !$past(uclk_q)));

    // R5: bus data changes only on falling update edges
    assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_q) |-> !uclk_q);

    // R5: update clock high level lasts one system cycle
    assert_half_rate_R5: assert property (@(posedge clk) disable iff (rst)
        uclk_q |=> !uclk_q);

    // R6: divider release happens with the update clock low
    assert_release_low_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(drst_q) |-> !uclk_q);

endmodule

// File: rtl/iqdac_feed.sv
module iqdac_feed
    import iqdac_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              in_ready,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_wr,
    output logic              bus_chsel,
    output logic              upd_clk,
    output logic              div_rst,
    output logic              underrun
);
    slot_t             slot_nxt;
    logic              take;
    logic [DATA_W-1:0] load_i;
    logic [DATA_W-1:0] held_q;

    assign in_ready = take;

    iqdac_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .slot_nxt (slot_nxt),
        .take_o   (take)
    );

    iqdac_pair_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .in_valid   (in_valid),
        .in_i       (in_i),
        .in_q       (in_q),
        .load_i     (load_i),
        .held_q     (held_q),
        .underrun_o (underrun)
    );

    iqdac_pins #(.DATA_W(DATA_W)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .slot_nxt (slot_nxt),
        .load_i   (load_i),
        .load_q   (held_q),
        .data_q   (bus_data),
        .wr_q     (bus_wr),
        .chsel_q  (bus_chsel),
        .uclk_q   (upd_clk),
        .drst_q   (div_rst)
    );

endmodule

// File: tb/test_iqdac_feed.sv
`timescale 1ns/1ps
module test_iqdac_feed;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_i = '0;
    logic [7:0] in_q = '0;
    logic       in_ready, bus_wr, bus_chsel, upd_clk, div_rst, underrun;
    logic [7:0] bus_data;

    always #4 clk = ~clk;

    iqdac_feed #(.DATA_W(8), .HOLD_CYC(H)) i_iqdac_feed (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .in_ready(in_ready), .bus_data(bus_data), .bus_wr(bus_wr),
        .bus_chsel(bus_chsel), .upd_clk(upd_clk), .div_rst(div_rst),
        .underrun(underrun)
    );

    int nchecks = 0;
    int nerr = 0;
    int cyc = 0, hi_cnt = 0, last_rdy = -1, last_com = -1;
    int idx = 0, ncom = 0, n_ur = 0;
    logic [7:0] exp_qi [0:255];
    logic [7:0] exp_qq [0:255];
    logic [7:0] wp = 0, rp = 0;
    logic [7:0] last_i = 0, last_q = 0, lat1 = 0, lat2 = 0;
    logic w1 = 0, w2 = 0, par = 0, exp_ur = 0;
    logic p_clk = 0, p_wr = 0, p_sel = 0, p_rst = 1;
    logic [7:0] p_data = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] gi(input int k);
        if (k == 0) return 8'hFF;
        if (k == 1) return 8'h00;
        return 8'(k * 53 + 17);
    endfunction

    function automatic logic [7:0] gq(input int k);
        return ~gi(k) ^ 8'(k);
    endfunction

    task automatic observe(input string rtag);
        if (rst) begin
            chk(div_rst == 1'b1, rtag, div_rst, 1);
            chk({bus_data, bus_wr, bus_chsel, upd_clk, in_ready, underrun} == '0,
                rtag, {bus_data, bus_wr, bus_chsel, upd_clk, in_ready, underrun}, 0);
            cyc = 0; hi_cnt = 1; last_rdy = -1; last_com = -1;
            wp = 0; rp = 0; last_i = 0; last_q = 0;
            w1 = 0; w2 = 0; par = 0;
        end else begin
            cyc++;
            if (bus_chsel != p_sel)
                chk(!upd_clk && !bus_wr, "R3 select moved with clk/wr high", {upd_clk, bus_wr}, 0);
            if (bus_wr && !p_wr)
                chk(upd_clk && !p_clk, "R4 write rise without clock rise", {p_clk, upd_clk}, 1);
            if (cyc >= H + 1)
                chk(upd_clk != p_clk, "R5 update clock not toggling", upd_clk, !p_clk);
            if (bus_data != p_data)
                chk(!upd_clk, "R5 data changed with clock high", upd_clk, 0);
            if (div_rst) hi_cnt++;
            if (!div_rst && p_rst) begin
                chk(hi_cnt == H + 4, "R6 divider reset length", hi_cnt, H + 4);
                chk(!upd_clk, "R6 release with clock high", upd_clk, 0);
            end
            if (div_rst) par = 0;
            // commit happens before the write that shares the edge
            if (upd_clk && !p_clk && !div_rst) begin
                if (!par) begin
                    ncom++;
                    chk(w1 && w2, "R6 commit before both writes", {w1, w2}, 3);
                    if (last_com < 0) chk(cyc == H + 5, "R10 first commit cycle", cyc, H + 5);
                    else chk(cyc - last_com == 4, "R10 commit spacing", cyc - last_com, 4);
                    last_com = cyc;
                    if (rp == wp) begin
                        chk(0, "R10 commit with no pair expected", 0, 1);
                    end else begin
                        chk(lat1 == exp_qi[rp], "R2 committed I", lat1, exp_qi[rp]);
                        chk(lat2 == exp_qq[rp], "R2 committed Q", lat2, exp_qq[rp]);
                        rp++;
                    end
                    w1 = 0; w2 = 0;
                end
                par = ~par;
            end
            if (bus_wr && !p_wr) begin
                if (bus_chsel) begin lat1 = bus_data; w1 = 1; end
                else begin lat2 = bus_data; w2 = 1; end
            end
            if (in_ready) begin
                if (last_rdy < 0) chk(cyc == H - 1, "R7 first ready cycle", cyc, H - 1);
                else chk(cyc - last_rdy == 4, "R7 ready spacing", cyc - last_rdy, 4);
                last_rdy = cyc;
            end
            chk(underrun == exp_ur, "R8 underrun flag", underrun, exp_ur);
            if (underrun) n_ur++;
        end
        p_clk = upd_clk; p_wr = bus_wr; p_sel = bus_chsel; p_rst = div_rst; p_data = bus_data;
    endtask

    task automatic step(input logic v, input logic r, input string rtag);
        rst = r; in_valid = v; in_i = gi(idx); in_q = gq(idx);
        exp_ur = 0;
        if (!r && in_ready) begin
            if (v) begin last_i = in_i; last_q = in_q; idx++; end
            else exp_ur = 1;
            exp_qi[wp] = last_i; exp_qq[wp] = last_q; wp++;
        end
        @(negedge clk);
        observe(rtag);
    endtask

    task automatic do_reset(input string rtag);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, rtag);
    endtask

    task automatic t_reset();
        do_reset("R1 reset state");
        chk(div_rst && !upd_clk && !in_ready, "R1 control lines after reset",
            {div_rst, upd_clk, in_ready}, 4);
    endtask

    task automatic t_stream();
        int c0, n;
        do_reset("R1 reset state");
        idx = 0; c0 = ncom; n = 9 + 4 * 12;
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, "R1");
        chk(ncom - c0 == (n - (H + 5)) / 4 + 1, "R10 commits in stream",
            ncom - c0, (n - (H + 5)) / 4 + 1);
    endtask

    task automatic t_gaps();
        int u0;
        do_reset("R1 reset state");
        u0 = n_ur;
        for (int k = 0; k < 60; k++) step((k % 7) < 3, 1'b0, "R1");
        chk(n_ur > u0, "R8 gaps produced underruns", n_ur - u0, 1);
    endtask

    task automatic t_no_data();
        int u0;
        do_reset("R1 reset state");
        u0 = n_ur;
        for (int k = 0; k < 25; k++) step(1'b0, 1'b0, "R1");
        chk(n_ur - u0 == 6, "R8 underrun per slot with no data", n_ur - u0, 6);
    endtask

    task automatic t_midreset();
        do_reset("R1 reset state");
        for (int k = 0; k < 23; k++) step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R9 mid-stream reset state");
        for (int k = 0; k < 30; k++) step(1'b1, 1'b0, "R9");
        chk(last_com >= 0, "R9 commits resume after reset", last_com, H + 5);
    endtask

    initial begin
        #800000;
        nerr++;
        nchecks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_stream();
        t_gaps();
        t_no_data();
        t_midreset();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule